// File: doc/BRIEF.md
# Indirect Configuration Register Port

This block lets a host bus reach a small bank of internal configuration registers through a pointer/data pair. The host first stores a 32-bit pointer through the pointer port. The pointer names one register by its byte offset. The host then reads or writes that register through the data port. Any number of data accesses can follow a single pointer write, because the pointer keeps its value until the host writes it again.

The positions of both ports depend on the active address layout. Layout A places each port at a fixed address, and a relocation flag moves both ports to a second pair of fixed addresses. Layout B decodes each port as a wide window in which every word is an alias of the same port. The layout select and the relocation flag are captured only while the bus is idle, so a transaction in flight is always decoded under one consistent layout.

Inside the data window, the two low address bits and the access size choose the byte lanes that are affected. Each register has a mask of writable bits. Reserved bits always read back as zero.

Top module: `cfg_indirect_port`

## Requirements
- R1: After synchronous reset, the pointer and every register hold zero, and `bus_ack` and `bus_rdata` are zero.
- R2: With `map_b`=0 and `reloc`=0, the pointer port is the single address 0x8000_0CF8 and the data port is any address from 0x8000_0CFC to 0x8000_0CFF.
- R3: With `map_b`=0 and `reloc`=1, the pointer port is 0x8000_0CF8's replacement 0x8006_7018 and the data port is 0x8006_701C to 0x8006_701F. The layout-A normal addresses are then not decoded.
- R4: With `map_b`=1, the pointer port is every address from 0xFEC0_0000 to 0xFEDF_FFFF whose two low bits are zero, and the data port is every address from 0xFEE0_0000 to 0xFEEF_FFFF. All of these alias to the same two ports, and `reloc` has no effect.
- R5: A request (`bus_req` high for one cycle) that hits either port gets `bus_ack` high in the following cycle. Read data is presented in that same cycle. A request that hits no port gets no acknowledge, and `bus_rdata` stays zero.
- R6: A write to the pointer port loads all 32 bits of `bus_wdata`, whatever the access size. A read of the pointer port returns the pointer. The pointer is unchanged by data-port accesses and by changes of layout.
- R7: A pointer is valid only when bits 31:8 equal 0x800000 and the offset field, bits 7:2, is below NREGS (16 by default). When the pointer is not valid, a data write is acknowledged but changes nothing, and a data read returns 0xFFFF_FFFF.
- R8: Access size encoding: 0 is byte, 1 is halfword, 2 or 3 is word. A byte access affects lane addr[1:0]. A halfword access affects lanes {addr[1],0} and {addr[1],1}. A word access affects all four lanes. Write data sits in the lanes it updates, lane n being bits 8n+7:8n, with bit 0 the least significant. A data read returns the whole selected register.
- R9: The writable mask of register k is 0xFFFF_FFFF shifted right by k. Masked-out bits never take a written value and read back as zero.
- R10: `map_b` and `reloc` take effect only through a cycle in which `bus_req` is low. A request is decoded with the values captured in the most recent such cycle, even when the inputs change in the request cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_b | input | 1 | Layout select: 0 selects layout A, 1 selects layout B |
| reloc | input | 1 | Relocated port addresses under layout A |
| bus_req | input | 1 | One-cycle transaction request |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 32 | Byte address |
| bus_size | input | 2 | Access size (0 byte, 1 half, 2 or 3 word) |
| bus_wdata | input | 32 | Write data, in lane position |
| bus_ack | output | 1 | Registered acknowledge of a decoded request |
| bus_rdata | output | 32 | Registered read data, valid with `bus_ack` |

## Verification
Layout capture and transaction decode can land on the same clock edge. This happens when the host flips `map_b` in the very cycle it raises `bus_req`. The bench provokes this by switching from layout B to layout A in the same cycle as a read issued at a layout-B data address. It expects that read to be acknowledged with the register contents under the old layout. After one idle cycle it expects the same address to go unacknowledged, and the layout-A address to reach the same register through the unchanged pointer.

// File: rtl/cfg_ip_pkg.sv
package cfg_ip_pkg;
  localparam int CFG_DW    = 32;
  localparam int CFG_LANES = CFG_DW / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  // fixed port addresses of layout A, normal and relocated
  localparam logic [31:0] A_PTR_ADDR   = 32'h8000_0CF8;
  localparam logic [31:0] A_DAT_ADDR   = 32'h8000_0CFC;
  localparam logic [31:0] A_PTR_RELOC  = 32'h8006_7018;
  localparam logic [31:0] A_DAT_RELOC  = 32'h8006_701C;
  // aliased windows of layout B, identified by their upper bits
  localparam logic [10:0] B_PTR_TOP11  = 11'h7F6;   // 0xFEC0_0000..0xFEDF_FFFF
  localparam logic [11:0] B_DAT_TOP12  = 12'hFEE;   // 0xFEE0_0000..0xFEEF_FFFF
  // pointer signature
  localparam logic [23:0] PTR_SIG      = 24'h80_0000;

  function automatic logic [CFG_DW-1:0] cfg_wmask(input logic [5:0] k);
    return {CFG_DW{1'b1}} >> k;
  endfunction
endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
  import cfg_ip_pkg::*;
(
  input  logic [31:0] addr,
  input  logic        map_b,
  input  logic        reloc,
  output logic        hit_ptr,
  output logic        hit_dat
);
  logic [31:0] a_ptr, a_dat;

  always_comb begin
    a_ptr = reloc ? A_PTR_RELOC : A_PTR_ADDR;
    a_dat = reloc ? A_DAT_RELOC : A_DAT_ADDR;
    if (map_b) begin
      hit_ptr = (addr[31:21] == B_PTR_TOP11) && (addr[1:0] == 2'b00);
      hit_dat = (addr[31:20] == B_DAT_TOP12);
    end else begin
      hit_ptr = (addr == a_ptr);
      hit_dat = (addr[31:2] == a_dat[31:2]);
    end
  end

  always_comb begin
    AST_PORTS_EXCLUSIVE: assert (!(hit_ptr && hit_dat)); // R4
  end
endmodule

// File: rtl/cfg_lane_sel.sv
module cfg_lane_sel
  import cfg_ip_pkg::*;
(
  input  logic [1:0]           addr_lo,
  input  logic [1:0]           size,
  output logic [CFG_LANES-1:0] lane_en
);
  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE: lane_en = 4'b0001 << addr_lo;
      SZ_HALF: lane_en = addr_lo[1] ? 4'b1100 : 4'b0011;
      default: lane_en = 4'b1111;
    endcase
  end

  always_comb begin
    AST_LANES_NONZERO: assert ($countones(lane_en) >= 1); // R8
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_ip_pkg::*;
#(
  parameter int NREGS = 16,
  localparam int IDXW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDXW-1:0]      idx,
  input  logic [CFG_LANES-1:0] lane_en,
  input  logic [CFG_DW-1:0]    wdata,
  output logic [CFG_DW-1:0]    rd
);
  logic [CFG_DW-1:0] regs [NREGS];
  logic [CFG_DW-1:0] wmask;

  assign wmask = cfg_wmask(6'(idx));
  assign rd    = regs[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREGS; r++) regs[r] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < CFG_LANES; b++) begin
        if (lane_en[b])
          regs[idx][b*8 +: 8] <= wdata[b*8 +: 8] & wmask[b*8 +: 8];
      end
    end
  end

  for (genvar r = 0; r < NREGS; r++) begin : g_chk
    localparam logic [CFG_DW-1:0] RMASK = ~cfg_wmask(6'(r));
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
      (regs[r] & RMASK) == '0); // R9
    AST_UNSELECTED_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && (idx == IDXW'(r))) |=> $stable(regs[r])); // R7
  end
endmodule

// File: rtl/cfg_indirect_port.sv
module cfg_indirect_port
  import cfg_ip_pkg::*;
#(
  parameter int NREGS = 16,
  localparam int IDXW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        map_b,
  input  logic        reloc,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [31:0] bus_addr,
  input  logic [1:0]  bus_size,
  input  logic [31:0] bus_wdata,
  output logic        bus_ack,
  output logic [31:0] bus_rdata
);
  logic [31:0]          ptr_q;
  logic                 map_q, reloc_q;
  logic                 hit_ptr, hit_dat, ptr_ok;
  logic [CFG_LANES-1:0] lane_en;
  logic [CFG_DW-1:0]    bank_rd;
  logic [IDXW-1:0]      idx;
  logic                 bank_we;

  cfg_port_decode u_dec (
    .addr    (bus_addr),
    .map_b   (map_q),
    .reloc   (reloc_q),
    .hit_ptr (hit_ptr),
    .hit_dat (hit_dat)
  );

  cfg_lane_sel u_lane (
    .addr_lo (bus_addr[1:0]),
    .size    (bus_size),
    .lane_en (lane_en)
  );

  assign idx     = ptr_q[IDXW+1:2];
  assign ptr_ok  = (ptr_q[31:8] == PTR_SIG) && ({1'b0, ptr_q[7:2]} < 7'(NREGS));
  assign bank_we = bus_req && bus_we && hit_dat && ptr_ok;

  cfg_reg_bank #(.NREGS(NREGS)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bank_we),
    .idx     (idx),
    .lane_en (lane_en),
    .wdata   (bus_wdata),
    .rd      (bank_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      map_q     <= 1'b0;
      reloc_q   <= 1'b0;
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_req && (hit_ptr || hit_dat);
      bus_rdata <= '0;
      if (!bus_req) begin
        map_q   <= map_b;
        reloc_q <= reloc;
      end
      if (bus_req && hit_ptr) begin
        if (bus_we) ptr_q     <= bus_wdata;
        else        bus_rdata <= ptr_q;
      end
      if (bus_req && hit_dat && !bus_we)
        bus_rdata <= ptr_ok ? bank_rd : '1;
    end
  end

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> $past(bus_req)); // R5
  AST_NO_ACK_UNDECODED: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !hit_ptr && !hit_dat) |=> !bus_ack); // R5
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bus_ack |-> (bus_rdata == '0)); // R5
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_we && hit_ptr) |=> $stable(ptr_q)); // R6
  AST_LAYOUT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> ($stable(map_q) && $stable(reloc_q))); // R10
endmodule

// File: tb/cfg_indirect_port_bench.sv
`timescale 1ns/1ps
module cfg_indirect_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        map_b = 1'b0, reloc = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [1:0]  bus_size = 2'd2;
  logic        bus_ack;
  logic [31:0] bus_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cfg_indirect_port u_cfg_indirect_port (
    .clk(clk), .rst(rst), .map_b(map_b), .reloc(reloc),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic        ack;
    logic [31:0] rdata;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h8000_0CF8, 2'd2, 32'h8000_0004, 1'b1, 32'h0,         4'd6}, // R6
    '{1'b0, 32'h8000_0CF8, 2'd2, 32'h0,         1'b1, 32'h8000_0004, 4'd6}, // R6
    '{1'b1, 32'h8000_0CFC, 2'd2, 32'hFFFF_FFFF, 1'b1, 32'h0,         4'd9}, // R9
    '{1'b0, 32'h8000_0CFC, 2'd2, 32'h0,         1'b1, 32'h7FFF_FFFF, 4'd9}, // R9
    '{1'b1, 32'h8000_0CFD, 2'd0, 32'h0000_AA00, 1'b1, 32'h0,         4'd8}, // R8
    '{1'b0, 32'h8000_0CFC, 2'd2, 32'h0,         1'b1, 32'h7FFF_AAFF, 4'd8}, // R8
    '{1'b1, 32'h8000_0CFE, 2'd1, 32'h1234_0000, 1'b1, 32'h0,         4'd8}, // R8
    '{1'b0, 32'h8000_0CFE, 2'd2, 32'h0,         1'b1, 32'h1234_AAFF, 4'd2}, // R2
    '{1'b1, 32'h8000_0CFF, 2'd1, 32'hF678_0000, 1'b1, 32'h0,         4'd8}, // R8
    '{1'b0, 32'h8000_0CFF, 2'd2, 32'h0,         1'b1, 32'h7678_AAFF, 4'd8}, // R8
    '{1'b1, 32'h8000_0CFC, 2'd0, 32'h1234_5655, 1'b1, 32'h0,         4'd8}, // R8
    '{1'b0, 32'h8000_0CFD, 2'd2, 32'h0,         1'b1, 32'h7678_AA55, 4'd8}, // R8
    '{1'b1, 32'h8000_0CF8, 2'd0, 32'h8000_003C, 1'b1, 32'h0,         4'd6}, // R6
    '{1'b1, 32'h8000_0CFC, 2'd3, 32'hFFFF_FFFF, 1'b1, 32'h0,         4'd9}, // R9
    '{1'b0, 32'h8000_0CFC, 2'd2, 32'h0,         1'b1, 32'h0001_FFFF, 4'd9}, // R9
    '{1'b1, 32'h8000_0CF8, 2'd2, 32'h0000_0004, 1'b1, 32'h0,         4'd7}, // R7
    '{1'b1, 32'h8000_0CFC, 2'd2, 32'hDEAD_BEEF, 1'b1, 32'h0,         4'd7}, // R7
    '{1'b0, 32'h8000_0CFC, 2'd2, 32'h0,         1'b1, 32'hFFFF_FFFF, 4'd7}, // R7
    '{1'b1, 32'h8000_0CF8, 2'd2, 32'h8100_0004, 1'b1, 32'h0,         4'd7}, // R7
    '{1'b0, 32'h8000_0CFC, 2'd2, 32'h0,         1'b1, 32'hFFFF_FFFF, 4'd7}, // R7
    '{1'b1, 32'h8000_0CF8, 2'd2, 32'h8000_0040, 1'b1, 32'h0,         4'd7}, // R7
    '{1'b0, 32'h8000_0CFC, 2'd2, 32'h0,         1'b1, 32'hFFFF_FFFF, 4'd7}, // R7
    '{1'b1, 32'h8000_0CF8, 2'd2, 32'h8000_0004, 1'b1, 32'h0,         4'd7}, // R7
    '{1'b0, 32'h8000_0CFC, 2'd2, 32'h0,         1'b1, 32'h7678_AA55, 4'd7}, // R7
    '{1'b0, 32'h8006_7018, 2'd2, 32'h0,         1'b0, 32'h0,         4'd3}, // R3
    '{1'b0, 32'h8000_0CF9, 2'd2, 32'h0,         1'b0, 32'h0,         4'd5}, // R5
    '{1'b0, 32'h8000_0D00, 2'd2, 32'h0,         1'b0, 32'h0,         4'd5}, // R5
    '{1'b0, 32'h8000_0CF8, 2'd2, 32'h0,         1'b1, 32'h8000_0004, 4'd6}  // R6
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // one request cycle, then sample at the following falling edge, then one idle cycle
  task automatic run(input logic we, input logic [31:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output logic ack_o, output logic [31:0] rd_o);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
    @(negedge clk);
    ack_o = bus_ack; rd_o = bus_rdata;
    bus_req = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    @(negedge clk);
  endtask

  task automatic expect_acc(input string tag, input logic we, input logic [31:0] a,
                            input logic [1:0] sz, input logic [31:0] wd,
                            input logic exp_ack, input logic [31:0] exp_rd);
    logic        ak;
    logic [31:0] rd;
    run(we, a, sz, wd, ak, rd);
    check({tag, " ack"}, {31'd0, ak}, {31'd0, exp_ack});
    check({tag, " rdata"}, rd, exp_rd);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 ack after reset", {31'd0, bus_ack}, 32'd0);
    check("R1 rdata after reset", bus_rdata, 32'd0);
    expect_acc("R1 pointer reads zero", 1'b0, 32'h8000_0CF8, 2'd2, 32'h0, 1'b1, 32'h0);
    expect_acc("R7 zero pointer invalid", 1'b0, 32'h8000_0CFC, 2'd2, 32'h0, 1'b1, 32'hFFFF_FFFF);

    // table walk under layout A, normal addresses (R2)
    for (int i = 0; i < NV; i++) begin
      expect_acc($sformatf("R%0d vec %0d", VECS[i].rq, i), VECS[i].we, VECS[i].addr,
                 VECS[i].size, VECS[i].wdata, VECS[i].ack, VECS[i].rdata);
    end

    // R3: relocated layout A
    reloc = 1'b1;
    expect_acc("R3 normal ptr port gone", 1'b0, 32'h8000_0CF8, 2'd2, 32'h0, 1'b0, 32'h0);
    expect_acc("R3 reloc ptr write", 1'b1, 32'h8006_7018, 2'd2, 32'h8000_0008, 1'b1, 32'h0);
    expect_acc("R3 reloc data read", 1'b0, 32'h8006_701F, 2'd2, 32'h0, 1'b1, 32'h0);
    expect_acc("R3 reloc half write", 1'b1, 32'h8006_701E, 2'd1, 32'hABCD_0000, 1'b1, 32'h0);
    expect_acc("R3 R9 reloc readback", 1'b0, 32'h8006_701C, 2'd2, 32'h0, 1'b1, 32'h2BCD_0000);

    // R4: layout B aliased windows
    map_b = 1'b1;
    expect_acc("R4 layout A addr gone", 1'b0, 32'h8006_7018, 2'd2, 32'h0, 1'b0, 32'h0);
    expect_acc("R4 ptr alias write", 1'b1, 32'hFED0_1234, 2'd2, 32'h8000_000C, 1'b1, 32'h0);
    expect_acc("R4 ptr alias read", 1'b0, 32'hFEC0_0000, 2'd2, 32'h0, 1'b1, 32'h8000_000C);
    expect_acc("R4 unaligned ptr", 1'b0, 32'hFEC0_0002, 2'd2, 32'h0, 1'b0, 32'h0);
    expect_acc("R4 R8 data byte", 1'b1, 32'hFEE7_7771, 2'd0, 32'h0000_5500, 1'b1, 32'h0);
    expect_acc("R4 data alias read", 1'b0, 32'hFEEF_FFFC, 2'd2, 32'h0, 1'b1, 32'h0000_5500);

    // R10: layout change in the same cycle as a request is not yet in force
    begin
      logic        ak;
      logic [31:0] rd;
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = 32'hFEE0_0000; bus_size = 2'd2;
      map_b = 1'b0;
      @(negedge clk);
      ak = bus_ack; rd = bus_rdata;
      bus_req = 1'b0;
      @(negedge clk);
      check("R10 old layout ack", {31'd0, ak}, 32'd1);
      check("R10 old layout rdata", rd, 32'h0000_5500);
    end
    expect_acc("R10 new layout drops B", 1'b0, 32'hFEE0_0000, 2'd2, 32'h0, 1'b0, 32'h0);
    expect_acc("R10 R6 ptr survives switch", 1'b0, 32'h8006_701C, 2'd2, 32'h0, 1'b1, 32'h0000_5500);

    // R1: reset clears registers and pointer
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; reloc = 1'b0;
    expect_acc("R1 ptr cleared", 1'b0, 32'h8000_0CF8, 2'd2, 32'h0, 1'b1, 32'h0);
    expect_acc("R1 set ptr", 1'b1, 32'h8000_0CF8, 2'd2, 32'h8000_0004, 1'b1, 32'h0);
    expect_acc("R1 reg cleared", 1'b0, 32'h8000_0CFC, 2'd2, 32'h0, 1'b1, 32'h0);

    summary();
    $finish;
  end
endmodule